// File: doc/BRIEF.md
# Video Frame Sequencer

This block paces frames for a streaming video core. Software programs the frame geometry and the input and output color formats through a simple write/read register port, then writes a control word. The start bit launches one frame. The block walks a pixel counter across each line and a line counter down the frame, advancing one pixel per clock. It pulses an end-of-frame strobe on the last pixel and raises a sticky done flag.

If the auto-restart bit is set alongside start, the next frame follows on the very next cycle, so the core streams continuously. Writing zero to the control word ends streaming cleanly: the frame in flight runs to its end and no further frame is launched. The geometry is range-checked whenever a frame is about to begin. A value outside the legal range raises an error flag and blocks the launch. The width and height are copied into shadow registers at every frame launch, so software may reprogram them while a frame is in flight.

A synchronous clear input puts all sequencing state back to idle and leaves the configuration untouched. System software pulses it after each stop.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset the block is idle (idle_o=1, running_o=0, done_o=0, error_o=0), the control word reads 0, both format outputs read code 2, and width and height read 64.
- R2: Register offsets are: control 0x00 (bit 0 start, bit 7 auto-restart), status 0x08, input format 0x10, output format 0x18, width 0x20, height 0x28. Format codes are 2 bits: 0 RGB, 1 YCbCr 4:4:4, 2 YCbCr 4:2:2, 3 YCbCr 4:2:0. Written values read back one cycle after the read strobe, and the formats also drive in_fmt_o and out_fmt_o.
- R3: A frame launch needs a width in 64..8192 and a height in 64..4320. A start with any other geometry sets error_o (status bit 3), does not run, and leaves the start bit reading 0.
- R4: A start without auto-restart runs exactly width*height cycles. pix_x_o counts 0..width-1 within a line and line_y_o counts the lines. frame_end_o pulses once, on the last pixel. The block then goes idle and the start bit reads 0.
- R5: done_o is set at the end of every frame and shows in status bit 1. A status read returns it and clears it, so a second read shows 0.
- R6: With control word 0x81, a new frame begins on the cycle after the last pixel, with both counters at 0 and running_o held high.
- R7: Writing 0 to the control word during a frame lets that frame finish with its frame_end_o pulse and launches no further frame.
- R8: Width and height are sampled at frame launch. A change written mid-frame takes effect only from the next frame.
- R9: sync_clr_i returns running, start, auto-restart, done, error and both counters to their idle values, and keeps the format and geometry registers.
- R10: The status word carries running in bit 0, done in bit 1, idle in bit 2 and error in bit 3. A valid launch clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_clr_i | input | 1 | Synchronous return to idle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| in_fmt_o | output | 2 | Input color format code |
| out_fmt_o | output | 2 | Output color format code |
| pix_x_o | output | 14 | Pixel index within the line |
| line_y_o | output | 13 | Line index within the frame |
| frame_end_o | output | 1 | High on the last pixel of a frame |
| running_o | output | 1 | A frame is in progress |
| done_o | output | 1 | Sticky frame-complete flag |
| idle_o | output | 1 | No frame in progress |
| error_o | output | 1 | Last launch refused on geometry |

## Verification
The bench runs single frames at randomly drawn geometries from 64 to 72 on each side. It compares the exact run length and the single end pulse against width*height, which separates off-by-one errors in the pixel wrap from off-by-one errors in the line wrap. Continuous mode is timed pulse by pulse over two back-to-back frames and then stopped mid-frame, to show the difference between chaining and finishing. Random out-of-range widths and heights, on both the low and the high side, probe the launch gate. A mid-frame geometry write and a mid-frame synchronous clear show whether the sequencer reads live or latched state.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    FMT_RGB    = 2'd0,
    FMT_YUV444 = 2'd1,
    FMT_YUV422 = 2'd2,
    FMT_YUV420 = 2'd3
  } fmt_e;

  localparam logic [7:0] REG_CTRL   = 8'h00;
  localparam logic [7:0] REG_STATUS = 8'h08;
  localparam logic [7:0] REG_IN_FMT = 8'h10;
  localparam logic [7:0] REG_OUT_FMT = 8'h18;
  localparam logic [7:0] REG_WIDTH  = 8'h20;
  localparam logic [7:0] REG_HEIGHT = 8'h28;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_AUTO_BIT  = 7;
endpackage

// File: rtl/fseq_cfg_regs.sv
module fseq_cfg_regs
  import fseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int XW    = 14,
  parameter int YW    = 13,
  parameter int MIN_W = 64,
  parameter int MIN_H = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [XW-1:0] wd_x_i,
  input  logic [YW-1:0] wd_y_i,
  input  logic [1:0]    wd_fmt_i,
  output fmt_e          in_fmt_o,
  output fmt_e          out_fmt_o,
  output logic [XW-1:0] width_o,
  output logic [YW-1:0] height_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_fmt_o  <= FMT_YUV422;
      out_fmt_o <= FMT_YUV422;
      width_o   <= XW'(MIN_W);
      height_o  <= YW'(MIN_H);
    end else if (wr_en_i) begin
      case (addr_i)
        AW'(REG_IN_FMT):  in_fmt_o  <= fmt_e'(wd_fmt_i);
        AW'(REG_OUT_FMT): out_fmt_o <= fmt_e'(wd_fmt_i);
        AW'(REG_WIDTH):   width_o   <= wd_x_i;
        AW'(REG_HEIGHT):  height_o  <= wd_y_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fseq_geom_chk.sv
module fseq_geom_chk #(
  parameter int XW    = 14,
  parameter int YW    = 13,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192,
  parameter int MIN_H = 64,
  parameter int MAX_H = 4320
) (
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  output logic          ok_o
);
  localparam logic [XW-1:0] W_LO = XW'(MIN_W);
  localparam logic [XW-1:0] W_HI = XW'(MAX_W);
  localparam logic [YW-1:0] H_LO = YW'(MIN_H);
  localparam logic [YW-1:0] H_HI = YW'(MAX_H);

  assign ok_o = (width_i >= W_LO) && (width_i <= W_HI) &&
                (height_i >= H_LO) && (height_i <= H_HI);
endmodule

// File: rtl/fseq_scan_cnt.sv
module fseq_scan_cnt #(
  parameter int XW = 14,
  parameter int YW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          last_o
);
  logic [XW-1:0] wm1_q;
  logic [YW-1:0] hm1_q;

  assign last_o = (x_o == wm1_q) && (y_o == hm1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o   <= '0;
      y_o   <= '0;
      wm1_q <= '0;
      hm1_q <= '0;
    end else if (clr_i) begin
      x_o <= '0;
      y_o <= '0;
    end else if (load_i) begin
      // shadow geometry for the frame being launched
      x_o   <= '0;
      y_o   <= '0;
      wm1_q <= width_i - XW'(1);
      hm1_q <= height_i - YW'(1);
    end else if (adv_i) begin
      if (last_o) begin
        x_o <= '0;
        y_o <= '0;
      end else if (x_o == wm1_q) begin
        x_o <= '0;
        y_o <= y_o + YW'(1);
      end else begin
        x_o <= x_o + XW'(1);
      end
    end
  end

  assert_x_in_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o <= wm1_q) && (y_o <= hm1_q));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic ctrl_wr_i,
  input  logic wd_start_i,
  input  logic wd_auto_i,
  input  logic geom_ok_i,
  input  logic last_i,
  input  logic status_rd_i,
  output logic start_o,
  output logic auto_o,
  output logic running_o,
  output logic done_o,
  output logic error_o,
  output logic load_o
);
  logic start_eff, auto_eff, launch, chain, want, fail, finish;

  assign start_eff = ctrl_wr_i ? wd_start_i : start_o;
  assign auto_eff  = ctrl_wr_i ? wd_auto_i  : auto_o;
  assign launch    = !running_o && ctrl_wr_i && wd_start_i;
  assign chain     = running_o && last_i && start_eff && auto_eff;
  assign want      = launch || chain;
  assign load_o    = want && geom_ok_i;
  assign fail      = want && !geom_ok_i;
  assign finish    = running_o && last_i && !chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o   <= 1'b0;
      auto_o    <= 1'b0;
      running_o <= 1'b0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else if (sync_clr_i) begin
      start_o   <= 1'b0;
      auto_o    <= 1'b0;
      running_o <= 1'b0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        start_o <= wd_start_i;
        auto_o  <= wd_auto_i;
      end
      if (fail || finish) start_o <= 1'b0;

      if (load_o)               running_o <= 1'b1;
      else if (finish || fail)  running_o <= 1'b0;

      // end-of-frame set wins over a same-cycle status read
      if (running_o && last_i)  done_o <= 1'b1;
      else if (status_rd_i)     done_o <= 1'b0;

      if (fail)                 error_o <= 1'b1;
      else if (load_o)          error_o <= 1'b0;
    end
  end

  assert_done_on_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && last_i && !sync_clr_i) |=> done_o);
  assert_bad_geom_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail && !sync_clr_i) |=> (error_o && !running_o && !start_o));
  assert_oneshot_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && last_i && !auto_eff && !sync_clr_i) |=> (!running_o && !start_o));
  assert_clear_idles_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (!running_o && !start_o && !auto_o && !done_o && !error_o));
endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import fseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192,
  parameter int MIN_H = 64,
  parameter int MAX_H = 4320,
  localparam int XW   = $clog2(MAX_W + 1),
  localparam int YW   = $clog2(MAX_H + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_clr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    in_fmt_o,
  output logic [1:0]    out_fmt_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] line_y_o,
  output logic          frame_end_o,
  output logic          running_o,
  output logic          done_o,
  output logic          idle_o,
  output logic          error_o
);
  fmt_e          in_fmt, out_fmt;
  logic [XW-1:0] width;
  logic [YW-1:0] height;
  logic          geom_ok, last, load, start_bit, auto_bit;
  logic          ctrl_wr, status_rd;
  logic [DW-1:0] rd_mux;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ctrl_wr   = wr_en_i && (addr_i == AW'(REG_CTRL));
  assign status_rd = rd_en_i && (addr_i == AW'(REG_STATUS));

  fseq_cfg_regs #(.AW(AW), .XW(XW), .YW(YW), .MIN_W(MIN_W), .MIN_H(MIN_H)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i,
    .wd_x_i(wdata_i[XW-1:0]), .wd_y_i(wdata_i[YW-1:0]), .wd_fmt_i(wdata_i[1:0]),
    .in_fmt_o(in_fmt), .out_fmt_o(out_fmt), .width_o(width), .height_o(height)
  );

  fseq_geom_chk #(.XW(XW), .YW(YW), .MIN_W(MIN_W), .MAX_W(MAX_W),
                  .MIN_H(MIN_H), .MAX_H(MAX_H)) u_chk (
    .width_i(width), .height_i(height), .ok_o(geom_ok)
  );

  fseq_ctrl u_ctrl (
    .clk_i, .rst_ni, .sync_clr_i, .ctrl_wr_i(ctrl_wr),
    .wd_start_i(wdata_i[CTRL_START_BIT]), .wd_auto_i(wdata_i[CTRL_AUTO_BIT]),
    .geom_ok_i(geom_ok), .last_i(last), .status_rd_i(status_rd),
    .start_o(start_bit), .auto_o(auto_bit), .running_o(running_o),
    .done_o(done_o), .error_o(error_o), .load_o(load)
  );

  fseq_scan_cnt #(.XW(XW), .YW(YW)) u_cnt (
    .clk_i, .rst_ni, .clr_i(sync_clr_i), .load_i(load), .adv_i(running_o),
    .width_i(width), .height_i(height), .x_o(pix_x_o), .y_o(line_y_o), .last_o(last)
  );

  assign idle_o      = !running_o;
  assign frame_end_o = running_o && last;
  assign in_fmt_o    = in_fmt;
  assign out_fmt_o   = out_fmt;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(REG_CTRL): begin
        rd_mux[CTRL_START_BIT] = start_bit;
        rd_mux[CTRL_AUTO_BIT]  = auto_bit;
      end
      AW'(REG_STATUS):  rd_mux[3:0] = {error_o, idle_o, done_o, running_o};
      AW'(REG_IN_FMT):  rd_mux[1:0] = in_fmt;
      AW'(REG_OUT_FMT): rd_mux[1:0] = out_fmt;
      AW'(REG_WIDTH):   rd_mux[XW-1:0] = width;
      AW'(REG_HEIGHT):  rd_mux[YW-1:0] = height;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assert_chain_origin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && start_bit && auto_bit && geom_ok && !wr_en_i && !sync_clr_i)
      |=> (running_o && pix_x_o == '0 && line_y_o == '0));
  assert_idle_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && $rose(error_o)) |-> !running_o);
endmodule

// File: tb/frame_seq_ctrl_bench.sv
module frame_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0, sync_clr = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  in_fmt, out_fmt;
  logic [13:0] pix_x;
  logic [12:0] line_y;
  logic        frame_end, running, done, idle, error;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_seq_ctrl u_frame_seq_ctrl (
    .clk_i(clk), .rst_ni, .sync_clr_i(sync_clr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .in_fmt_o(in_fmt),
    .out_fmt_o(out_fmt), .pix_x_o(pix_x), .line_y_o(line_y), .frame_end_o(frame_end),
    .running_o(running), .done_o(done), .idle_o(idle), .error_o(error)
  );

  function automatic int frame_cycles(int w, int h);
    return w * h;
  endfunction

  function automatic bit geom_legal(int w, int h);
    return (w >= 64) && (w <= 8192) && (h >= 64) && (h <= 4320);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  // count cycles while running, starting at the current negedge
  task automatic drain(output int cyc, output int ends);
    cyc = 0; ends = 0;
    while (running && cyc < 100000) begin
      cyc++;
      if (frame_end) ends++;
      @(negedge clk);
    end
  endtask

  task automatic one_shot(input int w, input int h);
    int cyc, ends;
    logic [31:0] d;
    wr(8'h20, w); wr(8'h28, h);
    wr(8'h00, 32'h1);
    drain(cyc, ends);
    check(cyc == frame_cycles(w, h), "R4 frame length", cyc, frame_cycles(w, h));
    check(ends == 1, "R4 end pulses", ends, 1);
    check(idle && !running, "R4 idle after frame", idle, 1);
    rd(8'h00, d);
    check(d == 0, "R4 start self-clear", d, 0);
    rd(8'h08, d);
    check(d == 32'h6, "R5 R10 status done+idle", d, 6);
    rd(8'h08, d);
    check(d == 32'h4, "R5 done cleared by read", d, 4);
  endtask

  initial begin
    logic [31:0] d;
    int cyc, ends, w, h, bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    check(idle && !running && !done && !error, "R1 flags", {idle, running, done, error}, 4'b1000);
    check(in_fmt == 2 && out_fmt == 2, "R1 formats", {in_fmt, out_fmt}, 4'b1010);
    rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
    rd(8'h20, d); check(d == 64, "R1 width", d, 64);
    rd(8'h28, d); check(d == 64, "R1 height", d, 64);

    // R2 format registers, random codes
    for (int i = 0; i < 4; i++) begin
      logic [1:0] fi, fo;
      fi = 2'($urandom); fo = 2'($urandom);
      wr(8'h10, fi); wr(8'h18, fo);
      check(in_fmt == fi && out_fmt == fo, "R2 format outputs", {in_fmt, out_fmt}, {fi, fo});
      rd(8'h10, d); check(d == fi, "R2 in format readback", d, fi);
      rd(8'h18, d); check(d == fo, "R2 out format readback", d, fo);
    end

    // R4 R5 one-shot frames at random legal geometry
    one_shot(64, 64);
    for (int i = 0; i < 4; i++) one_shot(64 + int'($urandom % 9), 64 + int'($urandom % 9));

    // R3 out-of-range geometry, random low/high picks
    for (int i = 0; i < 6; i++) begin
      case (i % 4)
        0: begin w = int'($urandom % 64);           h = 64; end
        1: begin w = 8193 + int'($urandom % 8000);  h = 64; end
        2: begin w = 64; h = int'($urandom % 64); end
        default: begin w = 64; h = 4321 + int'($urandom % 3800); end
      endcase
      wr(8'h20, w); wr(8'h28, h);
      check(!geom_legal(w, h), "R3 bench pick", w, h);
      wr(8'h00, 32'h81);
      check(error && !running, "R3 blocked launch", {error, running}, 2'b10);
      rd(8'h00, d); check(d[0] == 0, "R3 start reads 0", d, 0);
      rd(8'h08, d); check(d == 32'hC, "R3 R10 status error+idle", d, 12);
    end
    // boundary legal geometry, R10 valid launch clears error
    wr(8'h20, 8192); wr(8'h28, 64);
    wr(8'h00, 32'h1);
    check(running && !error, "R10 launch clears error", {running, error}, 2'b10);
    rd(8'h08, d); check(d == 32'h1, "R10 status running", d, 1);
    sync_clr = 1; @(negedge clk); sync_clr = 0;
    // R9 mid-frame clear
    check(!running && idle && !done && !error, "R9 idle after clear", running, 0);
    check(pix_x == 0 && line_y == 0, "R9 counters zero", pix_x, 0);
    rd(8'h00, d); check(d == 0, "R9 ctrl cleared", d, 0);
    rd(8'h20, d); check(d == 8192, "R9 width kept", d, 8192);
    repeat (5) @(negedge clk);
    check(!running, "R9 stays idle", running, 0);

    // R6 R7 auto-restart then stop
    w = 64 + int'($urandom % 5); h = 64;
    wr(8'h20, w); wr(8'h28, h);
    wr(8'h00, 32'h81);
    bad = 0;
    for (int i = 0; i < 2 * frame_cycles(w, h); i++) begin
      if (frame_end != (i == frame_cycles(w, h) - 1 || i == 2 * frame_cycles(w, h) - 1)) bad++;
      if (!running) bad++;
      if (i == frame_cycles(w, h) && (pix_x != 0 || line_y != 0)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 chained frames", bad, 0);
    check(running && pix_x == 0 && line_y == 0, "R6 third frame origin", pix_x, 0);
    wr(8'h00, 32'h0);
    drain(cyc, ends);
    check(cyc == frame_cycles(w, h) - 1, "R7 frame finishes", cyc, frame_cycles(w, h) - 1);
    check(ends == 1, "R7 single end", ends, 1);
    repeat (20) @(negedge clk);
    check(!running && idle, "R7 no relaunch", running, 0);
    rd(8'h08, d);

    // R8 geometry latched at launch
    wr(8'h20, 64); wr(8'h28, 64);
    wr(8'h00, 32'h1);
    wr(8'h20, 70);
    drain(cyc, ends);
    check(cyc == frame_cycles(64, 64) - 1, "R8 old width kept", cyc, frame_cycles(64, 64) - 1);
    wr(8'h00, 32'h1);
    drain(cyc, ends);
    check(cyc == frame_cycles(70, 64), "R8 new width used", cyc, frame_cycles(70, 64));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule